// File: doc/BRIEF.md
# Per-Target Priority Claim Arbiter

This block serves one interrupt target of a platform interrupt controller. Each cycle it takes the pending vector from the source gateways, the priority of every source, the target's enable vector and the target's threshold. From these it picks the best pending source that is enabled for the target. The best source is the one with the highest priority, and the lowest ID wins a tie. The block registers that source's ID and priority, and raises the target's interrupt line when the winning priority is strictly above the threshold.

A simple register-style port carries the claim/complete access. A read strobe claims the current best candidate. The claim ignores the threshold. The returned ID is held on the read-data output, and a one-cycle claim pulse goes to that source's gateway. A write strobe with a source ID sends a one-cycle completion pulse to that source's gateway. Source index k has ID k+1, and ID 0 means "no source".

Top module: `prio_claim_arbiter`

## Requirements
- R1: `best_id_o` and `best_prio_o` show, one cycle after the inputs, the ID and priority of the highest-priority source whose `pending_i` and `enable_i` bits are both 1. Priorities are `PRIO_W`-bit values, packed in `prio_i` with source k at bits [k*PRIO_W +: PRIO_W].
- R2: `irq_o` is 1 one cycle after the inputs exactly when a pending, enabled source exists and its winning priority is strictly greater than `threshold_i`.
- R3: A winning source with priority 0 never raises `irq_o`, whatever the threshold.
- R4: Among pending, enabled sources of equal priority, the lowest index wins. Source index k is reported as ID k+1.
- R5: A cycle with `rd_i`=1 captures the current best ID into `rdata_o` one cycle later, even when that priority is at or below the threshold. `rdata_o` holds its value until the next read.
- R6: When no source is both pending and enabled, `best_id_o`, `best_prio_o` and a claim read all return 0.
- R7: A cycle with `wr_i`=1 and `wdata_i` = ID in 1..N_SRC sets bit ID-1 of `complete_o` for exactly the next cycle. Any other `wdata_i` value, or `wr_i`=0, leaves `complete_o` at 0.
- R8: A claim read that returns ID j>0 sets bit j-1 of `claim_o` for exactly the next cycle. A read that returns 0 gives no claim pulse.
- R9: There is no global disable; only enables and threshold gate the target. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pending_i | input | N_SRC | Pending bits from the gateways |
| prio_i | input | N_SRC*PRIO_W | Packed per-source priorities |
| enable_i | input | N_SRC | Per-source enables for this target |
| threshold_i | input | PRIO_W | Target threshold |
| rd_i | input | 1 | Claim read strobe |
| wr_i | input | 1 | Completion write strobe |
| wdata_i | input | ID_W | Completion ID |
| rdata_o | output | ID_W | Last claimed ID |
| claim_o | output | N_SRC | Claim pulse per source |
| complete_o | output | N_SRC | Completion pulse per source |
| best_id_o | output | ID_W | Registered best candidate ID |
| best_prio_o | output | PRIO_W | Registered best candidate priority |
| irq_o | output | 1 | Target interrupt line |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers the best ID and priority, the interrupt line, the read data and the claim and completion pulses. The bench changes inputs on the falling edge. It waits one rising edge and compares at the next falling edge, against a model that uses the same inputs. The pulses are checked again on the following falling edge, after the strobes are dropped, to confirm that they last exactly one cycle.

// File: rtl/prio_claim_pkg.sv
package prio_claim_pkg;
  function automatic int id_width(int n_src);
    return $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/prio_arb_scan.sv
module prio_arb_scan #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic [N_SRC-1:0]        pending_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [N_SRC-1:0]        enable_i,
  output logic                    found_o,
  output logic [ID_W-1:0]         id_o,
  output logic [PRIO_W-1:0]       prio_o
);
  logic [PRIO_W-1:0] prio_a [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (pending_i[k] && enable_i[k] && (!found_o || prio_a[k] > prio_o)) begin
        found_o = 1'b1;
        id_o    = ID_W'(k + 1);
        prio_o  = prio_a[k];
      end
    end
  end
endmodule

// File: rtl/claim_port.sv
module claim_port #(
  parameter int N_SRC = 8,
  parameter int ID_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [ID_W-1:0]  wdata_i,
  input  logic [ID_W-1:0]  cand_id_i,
  output logic [ID_W-1:0]  rdata_o,
  output logic [N_SRC-1:0] claim_o,
  output logic [N_SRC-1:0] complete_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      claim_o    <= '0;
      complete_o <= '0;
    end else begin
      if (rd_i) rdata_o <= cand_id_i;
      for (int k = 0; k < N_SRC; k++) begin
        claim_o[k]    <= rd_i && (cand_id_i == ID_W'(k + 1));
        complete_o[k] <= wr_i && (wdata_i == ID_W'(k + 1));
      end
    end
  end

  assert_claim_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_o));
  assert_claim_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|claim_o) |-> (rdata_o != '0));
  assert_complete_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(complete_o));
  assert_complete_needs_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (complete_o == '0));
  assert_rdata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/prio_claim_arbiter.sv
module prio_claim_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  localparam int ID_W  = prio_claim_pkg::id_width(N_SRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        pending_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [N_SRC-1:0]        enable_i,
  input  logic [PRIO_W-1:0]       threshold_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [ID_W-1:0]         wdata_i,
  output logic [ID_W-1:0]         rdata_o,
  output logic [N_SRC-1:0]        claim_o,
  output logic [N_SRC-1:0]        complete_o,
  output logic [ID_W-1:0]         best_id_o,
  output logic [PRIO_W-1:0]       best_prio_o,
  output logic                    irq_o
);
  logic              found;
  logic [ID_W-1:0]   cand_id;
  logic [PRIO_W-1:0] cand_prio;

  prio_arb_scan #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_scan (
    .pending_i (pending_i),
    .prio_i    (prio_i),
    .enable_i  (enable_i),
    .found_o   (found),
    .id_o      (cand_id),
    .prio_o    (cand_prio)
  );

  claim_port #(.N_SRC(N_SRC), .ID_W(ID_W)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .cand_id_i  (cand_id),
    .rdata_o    (rdata_o),
    .claim_o    (claim_o),
    .complete_o (complete_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_id_o   <= '0;
      best_prio_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      best_id_o   <= cand_id;
      best_prio_o <= cand_prio;
      irq_o       <= found && (cand_prio > threshold_i);
    end
  end

  assert_irq_above_thr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (best_prio_o > $past(threshold_i)));
  assert_irq_nonzero_prio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (best_prio_o != '0) && (best_id_o != '0));
  assert_none_is_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_id_o == '0) |-> (best_prio_o == '0) && !irq_o);
  assert_id_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    best_id_o <= ID_W'(N_SRC));
endmodule

// File: tb/prio_claim_arbiter_test.sv
module prio_claim_arbiter_test;
  localparam int N_SRC  = 8;
  localparam int PRIO_W = 3;
  localparam int ID_W   = prio_claim_pkg::id_width(N_SRC);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_SRC-1:0] pending = '0, enable = '0;
  logic [N_SRC*PRIO_W-1:0] prio = '0;
  logic [PRIO_W-1:0] thr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [ID_W-1:0] wdata = '0;
  logic [ID_W-1:0] rdata, best_id;
  logic [N_SRC-1:0] claim, complete;
  logic [PRIO_W-1:0] best_prio;
  logic irq;

  int total = 0, bad = 0;
  logic [ID_W-1:0] exp_id, exp_rdata = '0;
  logic [PRIO_W-1:0] exp_prio;
  logic exp_found;

  always #10 clk = ~clk;

  prio_claim_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pending_i(pending), .prio_i(prio),
    .enable_i(enable), .threshold_i(thr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .claim_o(claim), .complete_o(complete),
    .best_id_o(best_id), .best_prio_o(best_prio), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic calc();
    exp_found = 1'b0; exp_id = '0; exp_prio = '0;
    for (int k = 0; k < N_SRC; k++) begin
      logic [PRIO_W-1:0] p;
      p = prio[k*PRIO_W +: PRIO_W];
      if (pending[k] && enable[k] && (!exp_found || p > exp_prio)) begin
        exp_found = 1'b1; exp_id = ID_W'(k + 1); exp_prio = p;
      end
    end
  endtask

  // drive at negedge, check one edge later, then drop strobes and check pulses end
  task automatic step(input bit do_rd, input bit do_wr, input logic [ID_W-1:0] wid);
    logic [N_SRC-1:0] exp_claim, exp_comp;
    rd = do_rd; wr = do_wr; wdata = wid;
    calc();
    exp_claim = '0; exp_comp = '0;
    if (do_rd) begin
      exp_rdata = exp_id;
      if (exp_id != 0) exp_claim[exp_id-1] = 1'b1;
    end
    if (do_wr && wid >= 1 && wid <= N_SRC) exp_comp[wid-1] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(best_id == exp_id, "R1/R4/R6 best_id", best_id, exp_id);
    chk(best_prio == exp_prio, "R1 best_prio", best_prio, exp_prio);
    chk(irq == (exp_found && exp_prio > thr), "R2/R3 irq", irq, exp_found && exp_prio > thr);
    chk(rdata == exp_rdata, "R5 rdata", rdata, exp_rdata);
    chk(claim == exp_claim, "R8 claim", claim, exp_claim);
    chk(complete == exp_comp, "R7 complete", complete, exp_comp);
    if (do_rd || do_wr) begin
      rd = 1'b0; wr = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(claim == '0 && complete == '0, "R7/R8 one-cycle pulse", claim | complete, 0);
    end
  endtask

  function automatic logic [N_SRC*PRIO_W-1:0] all_prio(input logic [PRIO_W-1:0] v);
    logic [N_SRC*PRIO_W-1:0] r;
    for (int k = 0; k < N_SRC; k++) r[k*PRIO_W +: PRIO_W] = v;
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(irq == 0 && best_id == 0 && rdata == 0 && claim == 0 && complete == 0,
        "R9 reset outputs", irq, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9: pending everywhere but all-zero config -> nothing
    pending = '1;
    step(1'b0, 1'b0, '0);
    // R4 tie: equal priorities, lowest index wins
    enable = '1; prio = all_prio(3'd4); thr = 3'd1; pending = 8'b1010_0100;
    step(1'b1, 1'b0, '0);
    // R5: priority equal to threshold -> no irq but claim still returns
    thr = 3'd4;
    step(1'b1, 1'b0, '0);
    // R3: priority 0 with threshold 0
    prio = '0; thr = '0; pending = 8'b0001_0000;
    step(1'b1, 1'b0, '0);
    // R6: pending but disabled -> claim returns 0, no pulse
    enable = 8'b1110_1111;
    step(1'b1, 1'b0, '0);
    // R7: out-of-range and zero completion IDs
    step(1'b0, 1'b1, ID_W'(0));
    step(1'b0, 1'b1, ID_W'(N_SRC + 1));
    step(1'b0, 1'b1, ID_W'(N_SRC));
    step(1'b0, 1'b1, ID_W'(1));
    // R1: highest priority beats lower index
    enable = '1; prio = all_prio(3'd2); prio[6*PRIO_W +: PRIO_W] = 3'd7;
    pending = 8'b0100_0011; thr = 3'd6;
    step(1'b1, 1'b1, ID_W'(3));
    for (int i = 0; i < 400; i++) begin
      pending = N_SRC'($urandom);
      enable  = N_SRC'($urandom);
      prio    = (N_SRC*PRIO_W)'($urandom);
      thr     = PRIO_W'($urandom);
      step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, ID_W'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule